// File: doc/BRIEF.md
# Layered Header Rule Filter Chain

This block decides the fate of a frame from its header fields alone. A parser, which is not part of this block, supplies the extracted fields of the frame. A lookup, also outside the block, supplies the per-flow rule set. The fields are the EtherType, VLAN ID, source MAC, IP protocol, source and destination IPv4 addresses, destination L4 port and ingress port. The block passes this descriptor through a fixed pipeline of single-cycle check stages, ordered by layer:

- EtherType
- VLAN
- source MAC
- protocol
- destination IP
- destination port
- source-address anti-spoof

A final stage applies optional source-address translation and registers a decision record.

Each check compares rule data with the frame's own fields in the cycle the descriptor occupies that stage. No check waits for payload. The first failing check sets a sticky drop mark and records its own number. Later stages carry the descriptor through untouched. One descriptor enters per cycle under valid/ready flow control, and its record leaves a fixed number of cycles later.

Top module: `hfc_filter_chain`

## Requirements
- R1: Every accepted descriptor yields exactly one record whose `out_verdict` is 0 (accept), 1 (drop) or 2 (modify); the value 3 never appears.
- R2: The layer-2 checks fail when `fr_etype != rl_etype` (cause 1), when `fr_vid != rl_vid` (cause 2), or when `fr_smac != rl_smac` (cause 3).
- R3: The layer-3 checks fail when `fr_proto != rl_proto` (cause 4), or when `(fr_dip & rl_dip_mask) != (rl_dip_val & rl_dip_mask)` (cause 5).
- R4: The port check fails (cause 6) unless `rl_port_lo <= fr_dport <= rl_port_hi`, both bounds inclusive.
- R5: The anti-spoof check fails (cause 7) when `(fr_sip & rl_sip_mask) != (rl_sip_val & rl_sip_mask)`.
- R6: When several enabled checks fail, `out_cause` is the lowest failing cause number, `out_verdict` is drop, and no later stage clears the drop.
- R7: Bit k of `rl_en` enables the check with cause k+1. A disabled check never fails, whatever the fields hold.
- R8: A descriptor that is not dropped and has `rl_nat_en` set gets verdict modify, and `out_sip` equals `rl_nat_sip`. In every other case `out_sip` equals `fr_sip`. A drop overrides translation.
- R9: With `out_ready` held high, one descriptor is taken per cycle. Its record appears after the eighth rising edge, counting the edge that accepts it.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the record outputs hold their values. No descriptor is lost or duplicated.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: The record carries the frame's ingress port on `out_ingress`. `out_cause` is 0 whenever the verdict is not drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Chain can take a descriptor |
| fr_etype | input | 16 | Frame EtherType |
| fr_vid | input | 12 | Frame VLAN ID |
| fr_smac | input | 48 | Frame source MAC |
| fr_proto | input | 8 | Frame IP protocol |
| fr_sip | input | 32 | Frame source IPv4 |
| fr_dip | input | 32 | Frame destination IPv4 |
| fr_dport | input | 16 | Frame destination L4 port |
| fr_ingress | input | 4 | Ingress port number |
| rl_en | input | 7 | Per-check enables, bit k for cause k+1 |
| rl_etype | input | 16 | Allowed EtherType |
| rl_vid | input | 12 | Allowed VLAN ID |
| rl_smac | input | 48 | Allowed source MAC |
| rl_proto | input | 8 | Allowed protocol |
| rl_dip_val | input | 32 | Destination IP match value |
| rl_dip_mask | input | 32 | Destination IP match mask |
| rl_port_lo | input | 16 | Lowest allowed port |
| rl_port_hi | input | 16 | Highest allowed port |
| rl_sip_val | input | 32 | Subscriber source prefix value |
| rl_sip_mask | input | 32 | Subscriber source prefix mask |
| rl_nat_en | input | 1 | Translate source address |
| rl_nat_sip | input | 32 | Replacement source address |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Record consumer ready |
| out_verdict | output | 2 | 0 accept, 1 drop, 2 modify |
| out_cause | output | 3 | Failing check number, 0 if none |
| out_ingress | output | 4 | Ingress port of the frame |
| out_sip | output | 32 | Source IPv4 after translation |

## Verification
The bench sweeps every combination of seven violated fields with all checks enabled. It then sweeps every enable mask with all fields violated. A chain that ranked its stages wrongly, or that let a later stage overwrite the drop mark, would report the wrong cause. One that ignored an enable would drop frames it should pass.

The port and prefix edges are probed at one below, at and one above each bound. An exclusive compare or an off-by-one mask would flip those verdicts.

Translation is tried on both dropped and passing frames, to catch a rewrite that leaks past a drop. A pseudo-random stall on the record side exposes any stage that advances while the output is held, which would lose or repeat records or break the fixed latency.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  parameter int ETW  = 16;
  parameter int VIDW = 12;
  parameter int MACW = 48;
  parameter int PROW = 8;
  parameter int IPW  = 32;
  parameter int PTW  = 16;
  parameter int INGW = 4;
  parameter int NCHK = 7;
  localparam int NSTG = NCHK + 1;
  localparam int SIDW = $clog2(NCHK + 1);

  typedef enum logic [1:0] {V_ACCEPT = 2'd0, V_DROP = 2'd1, V_MODIFY = 2'd2} verdict_e;

  typedef struct packed {
    logic [ETW-1:0]  etype;
    logic [VIDW-1:0] vid;
    logic [MACW-1:0] smac;
    logic [PROW-1:0] proto;
    logic [IPW-1:0]  sip;
    logic [IPW-1:0]  dip;
    logic [PTW-1:0]  dport;
    logic [INGW-1:0] ingress;
  } frame_t;

  typedef struct packed {
    logic [NCHK-1:0] en;
    logic [ETW-1:0]  etype;
    logic [VIDW-1:0] vid;
    logic [MACW-1:0] smac;
    logic [PROW-1:0] proto;
    logic [IPW-1:0]  dip_val;
    logic [IPW-1:0]  dip_mask;
    logic [PTW-1:0]  port_lo;
    logic [PTW-1:0]  port_hi;
    logic [IPW-1:0]  sip_val;
    logic [IPW-1:0]  sip_mask;
    logic            nat_en;
    logic [IPW-1:0]  nat_sip;
  } rule_t;

  typedef struct packed {
    logic            valid;
    logic            drop;
    logic [SIDW-1:0] cause;
    frame_t          f;
    rule_t           r;
  } pipe_t;
endpackage

// File: rtl/hfc_check_stage.sv
module hfc_check_stage
  import hfc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  pipe_t pi,
  output pipe_t po
);
  logic bad;

  if (IDX == 0) begin : g_etype
    assign bad = pi.f.etype != pi.r.etype;
  end else if (IDX == 1) begin : g_vlan
    assign bad = pi.f.vid != pi.r.vid;
  end else if (IDX == 2) begin : g_mac
    assign bad = pi.f.smac != pi.r.smac;
  end else if (IDX == 3) begin : g_proto
    assign bad = pi.f.proto != pi.r.proto;
  end else if (IDX == 4) begin : g_dip
    assign bad = (pi.f.dip & pi.r.dip_mask) != (pi.r.dip_val & pi.r.dip_mask);
  end else if (IDX == 5) begin : g_port
    assign bad = (pi.f.dport < pi.r.port_lo) || (pi.f.dport > pi.r.port_hi);
  end else if (IDX == 6) begin : g_spoof
    assign bad = (pi.f.sip & pi.r.sip_mask) != (pi.r.sip_val & pi.r.sip_mask);
  end else begin : g_none
    assign bad = 1'b0;
  end

  logic fail;
  assign fail = pi.valid && pi.r.en[IDX] && bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      po <= '0;
    end else if (adv) begin
      po <= pi;
      if (!pi.drop && fail) begin
        po.drop  <= 1'b1;
        po.cause <= SIDW'(IDX + 1);
      end
    end
  end

  // R6
  sticky_drop_chk: assert property (@(posedge clk) disable iff (rst)
    adv && pi.valid && pi.drop |=> po.drop && po.cause == $past(pi.cause));

  // R7
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    adv && pi.valid && !pi.drop && !pi.r.en[IDX] |=> !po.drop);
endmodule

// File: rtl/hfc_rewrite_stage.sv
module hfc_rewrite_stage
  import hfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  pipe_t           pi,
  output logic            out_valid,
  output logic [1:0]      out_verdict,
  output logic [SIDW-1:0] out_cause,
  output logic [INGW-1:0] out_ingress,
  output logic [IPW-1:0]  out_sip
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_verdict <= V_ACCEPT;
      out_cause   <= '0;
      out_ingress <= '0;
      out_sip     <= '0;
    end else if (adv) begin
      out_valid   <= pi.valid;
      out_cause   <= pi.cause;
      out_ingress <= pi.f.ingress;
      if (pi.drop) begin
        out_verdict <= V_DROP;
        out_sip     <= pi.f.sip;
      end else if (pi.r.nat_en) begin
        out_verdict <= V_MODIFY;
        out_sip     <= pi.r.nat_sip;
      end else begin
        out_verdict <= V_ACCEPT;
        out_sip     <= pi.f.sip;
      end
    end
  end

  // R8
  nat_applied_chk: assert property (@(posedge clk) disable iff (rst)
    adv && pi.valid && !pi.drop && pi.r.nat_en |=>
      out_verdict == V_MODIFY && out_sip == $past(pi.r.nat_sip));

  // R12
  cause_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_verdict == V_DROP) == (out_cause != '0)));

  // R1
  verdict_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_verdict != 2'd3);
endmodule

// File: rtl/hfc_filter_chain.sv
module hfc_filter_chain
  import hfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ETW-1:0]  fr_etype,
  input  logic [VIDW-1:0] fr_vid,
  input  logic [MACW-1:0] fr_smac,
  input  logic [PROW-1:0] fr_proto,
  input  logic [IPW-1:0]  fr_sip,
  input  logic [IPW-1:0]  fr_dip,
  input  logic [PTW-1:0]  fr_dport,
  input  logic [INGW-1:0] fr_ingress,
  input  logic [NCHK-1:0] rl_en,
  input  logic [ETW-1:0]  rl_etype,
  input  logic [VIDW-1:0] rl_vid,
  input  logic [MACW-1:0] rl_smac,
  input  logic [PROW-1:0] rl_proto,
  input  logic [IPW-1:0]  rl_dip_val,
  input  logic [IPW-1:0]  rl_dip_mask,
  input  logic [PTW-1:0]  rl_port_lo,
  input  logic [PTW-1:0]  rl_port_hi,
  input  logic [IPW-1:0]  rl_sip_val,
  input  logic [IPW-1:0]  rl_sip_mask,
  input  logic            rl_nat_en,
  input  logic [IPW-1:0]  rl_nat_sip,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [1:0]      out_verdict,
  output logic [SIDW-1:0] out_cause,
  output logic [INGW-1:0] out_ingress,
  output logic [IPW-1:0]  out_sip
);
  pipe_t stg [NCHK+1];
  logic  adv;

  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  always_comb begin
    stg[0].valid     = in_valid;
    stg[0].drop      = 1'b0;
    stg[0].cause     = '0;
    stg[0].f.etype   = fr_etype;
    stg[0].f.vid     = fr_vid;
    stg[0].f.smac    = fr_smac;
    stg[0].f.proto   = fr_proto;
    stg[0].f.sip     = fr_sip;
    stg[0].f.dip     = fr_dip;
    stg[0].f.dport   = fr_dport;
    stg[0].f.ingress = fr_ingress;
    stg[0].r.en       = rl_en;
    stg[0].r.etype    = rl_etype;
    stg[0].r.vid      = rl_vid;
    stg[0].r.smac     = rl_smac;
    stg[0].r.proto    = rl_proto;
    stg[0].r.dip_val  = rl_dip_val;
    stg[0].r.dip_mask = rl_dip_mask;
    stg[0].r.port_lo  = rl_port_lo;
    stg[0].r.port_hi  = rl_port_hi;
    stg[0].r.sip_val  = rl_sip_val;
    stg[0].r.sip_mask = rl_sip_mask;
    stg[0].r.nat_en   = rl_nat_en;
    stg[0].r.nat_sip  = rl_nat_sip;
  end

  for (genvar k = 0; k < NCHK; k++) begin : g_chk
    hfc_check_stage #(.IDX(k)) u_chk (
      .clk(clk), .rst(rst), .adv(adv), .pi(stg[k]), .po(stg[k+1])
    );
  end

  hfc_rewrite_stage u_rw (
    .clk(clk), .rst(rst), .adv(adv), .pi(stg[NCHK]),
    .out_valid(out_valid), .out_verdict(out_verdict), .out_cause(out_cause),
    .out_ingress(out_ingress), .out_sip(out_sip)
  );

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_verdict)
      && $stable(out_cause) && $stable(out_sip) && $stable(out_ingress));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_hfc_filter_chain.sv
module tb_hfc_filter_chain;
  import hfc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [ETW-1:0]  fr_etype = '0, rl_etype = '0;
  logic [VIDW-1:0] fr_vid = '0, rl_vid = '0;
  logic [MACW-1:0] fr_smac = '0, rl_smac = '0;
  logic [PROW-1:0] fr_proto = '0, rl_proto = '0;
  logic [IPW-1:0]  fr_sip = '0, fr_dip = '0, rl_dip_val = '0, rl_dip_mask = '0;
  logic [IPW-1:0]  rl_sip_val = '0, rl_sip_mask = '0, rl_nat_sip = '0;
  logic [PTW-1:0]  fr_dport = '0, rl_port_lo = '0, rl_port_hi = '0;
  logic [INGW-1:0] fr_ingress = '0, out_ingress;
  logic [NCHK-1:0] rl_en = '0;
  logic            rl_nat_en = 1'b0;
  logic [1:0]      out_verdict;
  logic [SIDW-1:0] out_cause;
  logic [IPW-1:0]  out_sip;

  hfc_filter_chain dut (.*);

  int nvec = 0, nfail = 0, cyc = 0, wr = 0, rd = 0;
  logic [1:0]      e_verd [DEPTH];
  logic [SIDW-1:0] e_cause [DEPTH];
  logic [IPW-1:0]  e_sip [DEPTH];
  logic [INGW-1:0] e_ing [DEPTH];
  int              e_acc [DEPTH];
  logic stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Base pattern: every field satisfies the rule
  task automatic base();
    rl_etype = 16'h0800; fr_etype = 16'h0800;
    rl_vid = 12'd5; fr_vid = 12'd5;
    rl_smac = 48'h0011_2233_4455; fr_smac = rl_smac;
    rl_proto = 8'd6; fr_proto = 8'd6;
    rl_dip_val = 32'h0A00_0100; rl_dip_mask = 32'hFFFF_FF00; fr_dip = 32'h0A00_0105;
    rl_port_lo = 16'd80; rl_port_hi = 16'd443; fr_dport = 16'd80;
    rl_sip_val = 32'hC0A8_0100; rl_sip_mask = 32'hFFFF_FF00; fr_sip = 32'hC0A8_0107;
    rl_nat_sip = 32'h6400_0001; rl_nat_en = 1'b0; rl_en = '1;
  endtask

  // Breaks field k when bit k of viol is set
  task automatic violate(input logic [NCHK-1:0] viol);
    if (viol[0]) fr_etype = fr_etype ^ 16'h1;
    if (viol[1]) fr_vid = fr_vid ^ 12'h1;
    if (viol[2]) fr_smac = fr_smac ^ 48'h1;
    if (viol[3]) fr_proto = fr_proto ^ 8'h1;
    if (viol[4]) fr_dip = fr_dip ^ 32'h100;
    if (viol[5]) fr_dport = 16'd444;
    if (viol[6]) fr_sip = fr_sip ^ 32'h100;
  endtask

  // Drives current fields, computes the expected record from the requirements
  task automatic push();
    logic [NCHK-1:0] bad;
    logic [SIDW-1:0] c;
    bad[0] = fr_etype != rl_etype;                                   // R2
    bad[1] = fr_vid != rl_vid;                                       // R2
    bad[2] = fr_smac != rl_smac;                                     // R2
    bad[3] = fr_proto != rl_proto;                                   // R3
    bad[4] = (fr_dip & rl_dip_mask) != (rl_dip_val & rl_dip_mask);   // R3
    bad[5] = !(fr_dport >= rl_port_lo && fr_dport <= rl_port_hi);    // R4
    bad[6] = (fr_sip & rl_sip_mask) != (rl_sip_val & rl_sip_mask);   // R5
    bad = bad & rl_en;                                               // R7
    c = '0;
    for (int k = NCHK - 1; k >= 0; k--) if (bad[k]) c = SIDW'(k + 1); // R6
    e_cause[wr] = c;
    e_verd[wr]  = (c != 0) ? 2'd1 : (rl_nat_en ? 2'd2 : 2'd0);       // R1, R8
    e_sip[wr]   = (c == 0 && rl_nat_en) ? rl_nat_sip : fr_sip;       // R8
    e_ing[wr]   = fr_ingress;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e_acc[wr] = cyc + 1;
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
    fr_ingress = fr_ingress + 1'b1;
  endtask

  logic held = 1'b0;
  logic [1:0] h_verd;
  logic [IPW-1:0] h_sip;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        // R10: held record unchanged
        chk(out_valid && out_verdict == h_verd && out_sip == h_sip, "R10 hold",
            {out_verdict, out_sip}, {h_verd, h_sip});
      end
      held = out_valid && !out_ready;
      h_verd = out_verdict; h_sip = out_sip;
      if (held) chk(!in_ready, "R10 in_ready", in_ready, 0);
      if (out_valid && out_ready) begin
        if (rd >= wr) chk(0, "R10 extra record", rd, wr);
        else begin
          chk(out_verdict == e_verd[rd], "R1/R6/R7 verdict", out_verdict, e_verd[rd]);
          chk(out_cause == e_cause[rd], "R6 cause", out_cause, e_cause[rd]);
          chk(out_sip == e_sip[rd], "R8 sip", out_sip, e_sip[rd]);
          chk(out_ingress == e_ing[rd], "R12 ingress", out_ingress, e_ing[rd]);
          if (!stall_mode)
            chk(cyc - e_acc[rd] == NSTG - 1, "R9 latency", cyc - e_acc[rd], NSTG - 1);
          rd++;
        end
      end
    end
  end

  initial begin
    base();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk(!out_valid, "R11 out_valid", out_valid, 0);
    chk(in_ready, "R11 in_ready", in_ready, 1);
    // Sweep all violation sets, all checks enabled (R6, R8 on passes)
    for (int v = 0; v < 128; v++) begin
      base(); violate(NCHK'(v)); rl_nat_en = (v % 3 == 0); push();
    end
    // Sweep all enable masks with every field violated (R7, R8 on drops)
    for (int e = 0; e < 128; e++) begin
      base(); violate('1); rl_en = NCHK'(e); rl_nat_en = e[0]; push();
    end
    // Port bounds inclusive (R4)
    foreach (e_acc[i]) if (i < 6) begin
      base(); fr_dport = (i < 3) ? PTW'(79 + i) : PTW'(439 + i); push();
    end
    // Prefix edges (R3, R5)
    base(); fr_dip = 32'h0A00_01FF; push();
    base(); fr_dip = 32'h0A00_0200; push();
    base(); fr_sip = 32'hC0A8_00FF; push();
    base(); fr_sip = 32'hC0A8_01FF; rl_nat_en = 1'b1; push();
    while (rd < wr && cyc < 20000) @(negedge clk);
    // Backpressure phase (R10)
    stall_mode = 1'b1;
    for (int v = 0; v < 128; v++) begin
      base(); violate(NCHK'(v * 37)); rl_nat_en = v[1]; push();
    end
    while (rd < wr && cyc < 20000) @(negedge clk);
    stall_mode = 1'b0;
    if (rd != wr) chk(0, "R10 watchdog", rd, wr);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule